// File: doc/BRIEF.md
# SMBus Byte-Data Read Host Controller

This block is a byte-wide, register-mapped host controller that performs one SMBus byte-data read on a two-wire open-drain bus. Software first writes a target address byte, which carries the 7-bit device address in bits [7:1] and a read flag in bit 0. It then writes a command byte and a control byte that selects the protocol. A further write of the control byte with its start bit set launches the transfer. Software then polls the status register until the busy flag drops, and reads the received byte from the data register.

The bus sequence is fixed: START, address with write, command byte, repeated START, address with read, one data byte from the target, a NACK from the host, then STOP. If the target refuses any of the three bytes it must acknowledge, the controller raises the device-error flag and closes the bus with STOP. The bus clock is derived from the system clock. Each bit is split into four phases of `QTR` system cycles. A target holding SCL low stretches the current phase. Status flags are write-one-to-clear. A level interrupt output follows the pending flags when its enable bit is set.

Top module: `smb_host_engine`

## Requirements
- R1: After reset, every register reads 0x00, SCL and SDA are released (both drive-low outputs 0) and the interrupt is low.
- R2: Writing the control register (offset 2) with bit 6 set, bits [4:2] = 3'b010, while the address register (offset 4) has bit 0 = 1, the block idle and no flag pending, sets busy (status bit 0) and the in-use flag (status bit 6) in the next cycle. Status then reads 0x41.
- R3: A started transfer puts these bytes on the bus in order: {addr,0}, command byte (offset 3), {addr,1}. The host answers the target's data byte with NACK.
- R4: SDA changes while SCL is high only to form START or STOP. A full transfer shows exactly two STARTs and one STOP.
- R5: After a fully acknowledged transfer, busy clears, the success flag (bit 1) is set, the received byte is in data 0 (offset 5), and status reads 0x42. With bit 6 masked it reads 0x02.
- R6: A NACK to the write address, the command or the read address sets the device-error flag (bit 2), ends with STOP, clears busy, and leaves success clear and data 0 unchanged. Status then reads 0x44. Success and device error are never set together.
- R7: Writing 1 to a status bit among bits 1, 2, 4 and 6 clears it. Writing 0 leaves it unchanged. Writing 0xFF clears all of them. Busy is not affected by status writes.
- R8: The start bit reads back as 0, while the control register returns bit 0 and bits [4:2]. A start written while busy neither restarts nor disturbs the running transfer.
- R9: A start with a protocol field other than 3'b010, or with address bit 0 = 0, sets the failed-transaction flag (bit 4). It leaves busy clear and causes no bus activity.
- R10: A start written while any of status bits 1, 2 or 4 is pending is ignored.
- R11: The interrupt output is high exactly when control bit 0 is set and at least one of status bits 1, 2 or 4 is set.
- R12: The SCL drive output holds each level for at least `QTR` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| scl_in | input | 1 | Sensed SCL level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Sensed SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Level completion interrupt |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data is combinational. The bench therefore reads back one cycle after each write. The busy and in-use flags are checked one cycle after the start write, and a blocked or refused start is checked the same way. Completion takes several hundred cycles that depend on `QTR`, so the bench polls busy once per cycle within a bounded limit. Only after busy has dropped does it compare status, data 0, the interrupt and the byte log of the target model. Expected values come from bench functions fed with directed cases and seeded random addresses, commands, data, NACK positions and interrupt enables.

// File: rtl/smb_host_engine.sv
`timescale 1ns/1ps
module smb_host_engine #(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       irq
);
  localparam int CW = $clog2(QTR) + 1;
  localparam logic [CW-1:0] TLAST = CW'(QTR - 1);
  localparam logic [2:0] A_STS = 3'd0, A_CTL = 3'd2, A_CMD = 3'd3, A_SAD = 3'd4, A_DAT = 3'd5;
  localparam logic [2:0] PROT_BDATA = 3'b010;

  typedef enum logic [2:0] {ST_S, ST_AW, ST_CMD, ST_SR, ST_AR, ST_RD, ST_P} stage_t;

  logic [7:0] cmd_q, sad_q, dat_q, sh, cmd_s;
  logic [6:0] adr_q;
  logic       ien_q;
  logic [2:0] prot_q;
  logic       busy, done, deverr, fail, inuse, nack_q;
  stage_t     stage, nxt_stage;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [CW-1:0] tcnt;
  logic       scl_lv, sda_lv;

  logic is_byte, is_rx, last_bit, pend, go_wr, go_ok, go_bad, stall, tick;
  assign is_byte  = (stage == ST_AW) || (stage == ST_CMD) || (stage == ST_AR) || (stage == ST_RD);
  assign is_rx    = (stage == ST_RD);
  assign last_bit = (bitn == 4'd8);
  assign pend     = done | deverr | fail;
  assign go_wr    = reg_wr && (reg_addr == A_CTL) && reg_wdata[6] && !busy && !pend;
  assign go_ok    = go_wr && (reg_wdata[4:2] == PROT_BDATA) && sad_q[0];
  assign go_bad   = go_wr && !go_ok;
  assign stall    = scl_lv && !scl_in;
  assign tick     = busy && (tcnt == TLAST) && !stall;

  always_comb begin
    case (stage)
      ST_S:    nxt_stage = ST_AW;
      ST_AW:   nxt_stage = nack_q ? ST_P : ST_CMD;
      ST_CMD:  nxt_stage = nack_q ? ST_P : ST_SR;
      ST_SR:   nxt_stage = ST_AR;
      ST_AR:   nxt_stage = nack_q ? ST_P : ST_RD;
      ST_RD:   nxt_stage = ST_P;
      default: nxt_stage = ST_S;
    endcase
  end

  always_comb begin
    scl_lv = 1'b1;
    sda_lv = 1'b1;
    if (busy) begin
      if (stage == ST_S || stage == ST_SR) begin
        case (ph)
          2'd0:    begin scl_lv = (stage == ST_S); sda_lv = 1'b1; end
          2'd1:    begin scl_lv = 1'b1; sda_lv = 1'b1; end
          2'd2:    begin scl_lv = 1'b1; sda_lv = 1'b0; end
          default: begin scl_lv = 1'b0; sda_lv = 1'b0; end
        endcase
      end else if (stage == ST_P) begin
        scl_lv = (ph != 2'd0);
        sda_lv = (ph >= 2'd2);
      end else begin
        scl_lv = (ph == 2'd1) || (ph == 2'd2);
        sda_lv = (last_bit || is_rx) ? 1'b1 : sh[7];
      end
    end
  end

  assign scl_oe = ~scl_lv;
  assign sda_oe = ~sda_lv;
  assign irq    = ien_q & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; sad_q <= '0; dat_q <= '0; sh <= '0; cmd_s <= '0; adr_q <= '0;
      ien_q <= 1'b0; prot_q <= '0;
      busy <= 1'b0; done <= 1'b0; deverr <= 1'b0; fail <= 1'b0; inuse <= 1'b0; nack_q <= 1'b0;
      stage <= ST_S; ph <= '0; bitn <= '0; tcnt <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_STS: begin
            if (reg_wdata[1]) done   <= 1'b0;
            if (reg_wdata[2]) deverr <= 1'b0;
            if (reg_wdata[4]) fail   <= 1'b0;
            if (reg_wdata[6]) inuse  <= 1'b0;
          end
          A_CTL: begin ien_q <= reg_wdata[0]; prot_q <= reg_wdata[4:2]; end
          A_CMD: cmd_q <= reg_wdata;
          A_SAD: sad_q <= reg_wdata;
          A_DAT: dat_q <= reg_wdata;
          default: ;
        endcase
      end
      if (go_bad) fail <= 1'b1;
      if (go_ok) begin
        busy  <= 1'b1; inuse <= 1'b1;
        stage <= ST_S; ph <= '0; bitn <= '0; tcnt <= '0; nack_q <= 1'b0;
        adr_q <= sad_q[7:1]; cmd_s <= cmd_q; sh <= {sad_q[7:1], 1'b0};
      end
      if (busy) begin
        if (tcnt != TLAST) tcnt <= tcnt + 1'b1;
        else if (!stall) tcnt <= '0;
        if (tick) begin
          ph <= ph + 2'd1;
          if (is_byte && ph == 2'd2) begin
            if (is_rx && !last_bit) sh <= {sh[6:0], sda_in};
            if (!is_rx && last_bit && sda_in) nack_q <= 1'b1;
          end
          if (ph == 2'd3) begin
            if (is_byte && !last_bit) begin
              bitn <= bitn + 4'd1;
              if (!is_rx) sh <= {sh[6:0], 1'b0};
            end else begin
              bitn  <= '0;
              stage <= nxt_stage;
              if (stage == ST_AW) sh <= cmd_s;
              if (stage == ST_SR) sh <= {adr_q, 1'b1};
              if (stage == ST_P) begin
                busy <= 1'b0;
                if (nack_q) deverr <= 1'b1;
                else begin done <= 1'b1; dat_q <= sh; end
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {1'b0, inuse, 1'b0, fail, 1'b0, deverr, done, busy};
      A_CTL:   reg_rdata = {3'b000, prot_q, 1'b0, ien_q};
      A_CMD:   reg_rdata = cmd_q;
      A_SAD:   reg_rdata = sad_q;
      A_DAT:   reg_rdata = dat_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  logic          scl_prev;
  logic [CW-1:0] scnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_prev <= 1'b0;
      scnt     <= '0;
    end else begin
      scl_prev <= scl_oe;
      if (scl_oe != scl_prev) scnt <= '0;
      else if (scnt != CW'(QTR)) scnt <= scnt + 1'b1;
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok |=> busy && inuse);

  // R10
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !busy && reg_wr && reg_addr == A_CTL && reg_wdata[6]) |=> !busy);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && deverr));

  // R9
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> !busy && !scl_oe && !sda_oe);

  // R8
  restart_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && reg_wr && reg_addr == A_CTL && reg_wdata[6]) |=> $stable(stage) && $stable(bitn) && busy);

  // R4
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (stage == ST_S || stage == ST_SR || stage == ST_P));

  // R12
  scl_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe != scl_prev) |-> (scnt >= TLAST));
endmodule

// File: tb/smb_host_engine_tb.sv
`timescale 1ns/1ps
module smb_host_engine_tb;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       s_pull;
  wire scl_b = ~scl_oe;
  wire sda_b = ~(sda_oe | s_pull);

  smb_host_engine #(.QTR(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_b), .scl_oe(scl_oe),
    .sda_in(sda_b), .sda_oe(sda_oe), .irq(irq));

  int checks = 0, errors = 0;
  bit fin = 0;

  // target model
  int nack_sel = 0;
  logic [7:0] s_tx = 8'h00;
  logic [7:0] slog [0:2];
  int nbytes = 0, nstart = 0, nstop = 0, bitc = 0, tbit = 0, mode = 0;
  bit active = 0, in_ack = 0, go_tx = 0, ack = 0;
  logic m_nack = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] ssh = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_pull <= 1'b0; p_scl = 1'b1; p_sda = 1'b1; mode = 0; active = 0;
    end else begin
      if (p_scl && scl_b && p_sda && !sda_b) begin
        if (!active) begin nbytes = 0; nstart = 0; nstop = 0; m_nack = 1'b0; end
        active = 1; nstart++; mode = 1; bitc = 0; in_ack = 0; tbit = 0; go_tx = 0;
        s_pull <= 1'b0;
      end else if (p_scl && scl_b && !p_sda && sda_b) begin
        active = 0; nstop++; mode = 0; s_pull <= 1'b0;
      end else if (!p_scl && scl_b) begin
        if (mode == 1 && !in_ack && bitc < 8) begin ssh = {ssh[6:0], sda_b}; bitc++; end
        else if (mode == 2 && tbit == 9) begin m_nack = sda_b; tbit = 10; end
      end else if (p_scl && !scl_b) begin
        if (mode == 1 && in_ack) begin
          in_ack = 0; bitc = 0; s_pull <= 1'b0;
          if (go_tx) begin mode = 2; s_pull <= !s_tx[7]; tbit = 1; end
        end else if (mode == 1 && bitc == 8) begin
          if (nbytes < 3) slog[nbytes] = ssh;
          case (nbytes)
            0: ack = (ssh == {SLV, 1'b0}) && nack_sel != 1;
            1: ack = (nack_sel != 2);
            2: ack = (ssh == {SLV, 1'b1}) && nack_sel != 3;
            default: ack = 0;
          endcase
          go_tx = ack && nbytes == 2;
          nbytes++;
          if (ack) begin in_ack = 1; s_pull <= 1'b1; end
          else mode = 0;
        end else if (mode == 2) begin
          if (tbit < 8) begin s_pull <= !s_tx[7 - tbit]; tbit++; end
          else if (tbit == 8) begin s_pull <= 1'b0; tbit = 9; end
        end
      end
      p_scl = scl_b; p_sda = sda_b;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  // 0 = all acked, 1/2/3 = NACK at write address / command / read address
  function automatic int nack_point(input logic [6:0] adr, input int nsel);
    if (adr != SLV || nsel == 1) return 1;
    if (nsel == 2) return 2;
    if (nsel == 3) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] exp_status(input int np);
    return (np == 0) ? 8'h42 : 8'h44;
  endfunction

  task automatic run_read(input logic [6:0] adr, input logic [7:0] cmd, input logic [7:0] d,
                          input int nsel, input bit ien, input bit dbl);
    logic [7:0] v;
    int np, lim;
    np = nack_point(adr, nsel);
    s_tx = d; nack_sel = nsel;
    wr(3'd0, 8'hFF);
    wr(3'd4, {adr, 1'b1});
    wr(3'd3, cmd);
    wr(3'd5, 8'h00);
    wr(3'd2, {7'b0000100, ien} | 8'h00);
    wr(3'd2, 8'h48 | {7'd0, ien});
    rd(3'd0, v);
    chk(v == 8'h41, "R2 busy and in-use after start", v, 8'h41);
    rd(3'd2, v);
    chk(v == (8'h08 | {7'd0, ien}), "R8 start bit reads zero", v, 8'h08 | {7'd0, ien});
    if (dbl) begin
      wr(3'd2, 8'h48 | {7'd0, ien});
      wr(3'd0, 8'h01);
      rd(3'd0, v);
      chk(v == 8'h41, "R7 busy unaffected by status write", v, 8'h41);
    end
    lim = 0;
    rd(3'd0, v);
    while (v[0] && lim < 5000) begin rd(3'd0, v); lim++; end
    chk(!v[0], "R5 busy clears", v, 8'h00);
    chk(v == exp_status(np), np == 0 ? "R5 status after success" : "R6 status after NACK", v, exp_status(np));
    chk((v & 8'hBF) == (np == 0 ? 8'h02 : 8'h04), "R5 masked status", v & 8'hBF, np == 0 ? 8'h02 : 8'h04);
    chk(!(v[1] && v[2]), "R6 success and device error exclusive", v, 8'h00);
    rd(3'd5, v);
    chk(v == (np == 0 ? d : 8'h00), np == 0 ? "R5 data 0 holds received byte" : "R6 data 0 unchanged", v, np == 0 ? d : 8'h00);
    chk(irq == ien, "R11 interrupt level", irq, ien);
    chk(nstop == 1 && scl_oe == 1'b0 && sda_oe == 1'b0, "R6 bus closed with STOP", nstop, 1);
    case (np)
      0: begin
        chk(nbytes == 3 && slog[0] == {adr, 1'b0} && slog[1] == cmd && slog[2] == {adr, 1'b1},
            "R3 byte order", {slog[0], slog[1], slog[2]}, {adr, 1'b0, cmd, adr, 1'b1});
        chk(m_nack == 1'b1, "R3 host NACKs data byte", m_nack, 1);
        chk(nstart == 2, "R4 two STARTs in a transfer", nstart, 2);
      end
      1: chk(nbytes == 1 && nstart == 1, "R6 stop after write address NACK", nbytes, 1);
      2: chk(nbytes == 2 && nstart == 1, "R6 stop after command NACK", nbytes, 2);
      default: chk(nbytes == 3 && nstart == 2, "R6 stop after read address NACK", nbytes, 3);
    endcase
  endtask

  initial begin
    logic [7:0] v;
    int ns;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    foreach (v[i]) ;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R1 register reset value", v, 8'h00);
    end
    chk(scl_oe == 1'b0 && sda_oe == 1'b0 && irq == 1'b0, "R1 bus released and irq low", {scl_oe, sda_oe, irq}, 0);

    run_read(SLV, 8'h3C, 8'hA5, 0, 1'b1, 1'b0);
    // R7 write-one-to-clear
    wr(3'd0, 8'h00); rd(3'd0, v);
    chk(v == 8'h42, "R7 zero write keeps flags", v, 8'h42);
    wr(3'd0, 8'h02); rd(3'd0, v);
    chk(v == 8'h40, "R7 clear success flag", v, 8'h40);
    chk(irq == 1'b0, "R11 interrupt drops with flags", irq, 0);
    wr(3'd0, 8'h40); rd(3'd0, v);
    chk(v == 8'h00, "R7 clear in-use flag", v, 8'h00);

    run_read(7'h22, 8'h10, 8'h77, 0, 1'b0, 1'b0);
    run_read(SLV, 8'h11, 8'h5A, 2, 1'b1, 1'b0);
    run_read(SLV, 8'h12, 8'hC3, 3, 1'b0, 1'b0);
    run_read(SLV, 8'hFE, 8'h00, 0, 1'b0, 1'b1);
    run_read(SLV, 8'h01, 8'hFF, 0, 1'b1, 1'b0);

    // R9 refused starts
    wr(3'd0, 8'hFF);
    ns = nstart;
    wr(3'd4, {SLV, 1'b0});
    wr(3'd2, 8'h49);
    rd(3'd0, v);
    chk(v == 8'h10, "R9 write direction refused", v, 8'h10);
    chk(irq == 1'b1, "R11 interrupt on failed flag", irq, 1);
    // R10 start while flag pending
    wr(3'd4, {SLV, 1'b1});
    wr(3'd2, 8'h49);
    rd(3'd0, v);
    chk(v == 8'h10, "R10 start blocked while pending", v, 8'h10);
    wr(3'd0, 8'hFF); rd(3'd0, v);
    chk(v == 8'h00, "R7 0xFF clears all flags", v, 8'h00);
    wr(3'd2, 8'h4C);
    rd(3'd0, v);
    chk(v == 8'h10, "R9 wrong protocol refused", v, 8'h10);
    repeat (40) @(negedge clk);
    chk(nstart == ns && scl_oe == 1'b0 && sda_oe == 1'b0, "R9 no bus activity", nstart, ns);

    v = 8'($urandom(32'h00C0FFEE));
    for (int k = 0; k < 8; k++) begin
      logic [6:0] ra;
      int rn;
      ra = ($urandom % 4 == 0) ? 7'($urandom) : SLV;
      rn = ($urandom % 3 == 0) ? int'($urandom % 4) : 0;
      run_read(ra, 8'($urandom), 8'($urandom), rn, 1'($urandom), 1'($urandom % 4 == 0));
    end

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule